// File: doc/BRIEF.md
# Saturating Cache Event Counter Unit

This unit sits beside a level-2 cache controller and counts cache events in two independent 32-bit counters. The cache drives a vector of one-cycle event strobes, one bit per event source code. Each counter has a configuration register. Its source field picks which strobe the counter follows, and its interrupt-mode field is stored and read back but has no function here. A single global enable bit in a control register starts and freezes both counters together.

Software reaches the unit through a simple single-cycle register port. A write takes effect at the next clock edge. Read data is combinational from the address and shows the state held before that cycle's edge. The per-counter registers are laid out in descending address order, so Counter1's registers sit below Counter0's.

A counter never wraps. Once it holds all ones it stays there until software writes a new value. Software polls the counters and restarts them from zero before they fill.

Top module: `cache_event_counter_unit`

## Requirements
- R1: After reset, every mapped register reads zero: the enable bit is clear and every counter is zero.
- R2: Address map (byte offsets): control at 0x00 with the enable at bit 0; Counter1 configuration at 0x04; Counter0 configuration at 0x08; Counter1 value at 0x0C; Counter0 value at 0x10. Counter i's registers sit at the Counter0 address minus 4*i. Any other address reads zero.
- R3: In the configuration register, bits [5:2] hold the source code and bits [1:0] hold the interrupt mode. Strobe input bit k carries event code k. While enabled, a counter adds exactly one on each clock edge at which its selected strobe is high. Strobes of other codes do not affect it.
- R4: While the enable bit is clear, neither counter changes except by a software write.
- R5: Source code 0 means disabled, and a counter with that code never increments.
- R6: A counter that holds 0xFFFFFFFF stays at 0xFFFFFFFF when further events arrive.
- R7: A write to a value register loads the written data at the next edge. If an event for that counter occurs in the same cycle, the written value wins.
- R8: Read data in a cycle is the register value held before that cycle's edge, including when an increment happens at that edge.
- R9: Codes 0xA to 0xF count only when EXTENDED_EVENTS is 1. With EXTENDED_EVENTS set to 0 they behave as code 0.
- R10: A configuration write keeps only bits [5:0]. Read-back returns those six bits with the upper bits zero, and the interrupt-mode bits have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr_i | input | 5 | Register byte address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| evt_strobe_i | input | 16 | One-cycle event strobes, bit k = event code k |

## Verification
The only state is the enable bit, two configuration registers and two counters, and every one of them can be read back in the cycle after it changes. A decode error that lets one counter follow the other's source shows up at the next read as a count that is too large or too small. A missing saturation guard shows up as the value 0 right after an event reaches a counter at 0xFFFFFFFF. A wrong write-versus-event priority shows up as the written value plus one. A reversed address layout swaps the two counters in the first test that gives them different counts.

// File: rtl/cecu_pkg.sv
// Shared constants and event codes for the cache event counter unit.
// Assumes byte addressing with 32-bit registers placed 4 bytes apart.
package cecu_pkg;
    localparam int CTRL_OFF        = 0;   // global control register
    localparam int CFG0_OFF        = 8;   // Counter0 configuration; Counter i at CFG0_OFF - STRIDE*i
    localparam int VAL0_OFF        = 16;  // Counter0 value; Counter i at VAL0_OFF - STRIDE*i
    localparam int STRIDE          = 4;
    localparam int MODE_W          = 2;   // interrupt-mode field width (bits [1:0])
    localparam int BASE_CODE_LIMIT = 10;  // codes below this exist without the extended set

    typedef enum logic [3:0] {
        EV_NONE       = 4'h0,
        EV_EVICT      = 4'h1,
        EV_DRD_HIT    = 4'h2,
        EV_DRD_REQ    = 4'h3,
        EV_DWR_HIT    = 4'h4,
        EV_DWR_REQ    = 4'h5,
        EV_DWT_REQ    = 4'h6,
        EV_IRD_HIT    = 4'h7,
        EV_IRD_REQ    = 4'h8,
        EV_WR_ALLOC   = 4'h9,
        EV_PF_ALLOC   = 4'hA,
        EV_XPF_HIT    = 4'hB,
        EV_XPF_ALLOC  = 4'hC,
        EV_SPEC_RCV   = 4'hD,
        EV_SPEC_CONF  = 4'hE,
        EV_XPF_RCV    = 4'hF
    } event_code_e;
endpackage

// File: rtl/cecu_regfile.sv
// Register file and address decode for the counter unit.
// Holds the global enable bit and one configuration word per counter.
// Produces value-register write strobes and a combinational read mux.
// Assumes single-cycle access: a write lands at the next edge, and a read
// reflects the state before that edge.
module cecu_regfile #(
    parameter int NUM_CTR = 2,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 5,
    parameter int SRC_W   = 4,
    parameter int MODE_W  = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ADDR_W-1:0]                addr_i,
    input  logic                             wr_i,
    input  logic [DATA_W-1:0]                wdata_i,
    output logic [DATA_W-1:0]                rdata_o,
    input  logic [NUM_CTR-1:0][DATA_W-1:0]   cnt_i,
    output logic                             glob_en_o,
    output logic [NUM_CTR-1:0][SRC_W-1:0]    src_o,
    output logic [NUM_CTR-1:0]               val_we_o,
    output logic [DATA_W-1:0]                val_wdata_o
);
    import cecu_pkg::*;

    localparam int CFG_W = SRC_W + MODE_W;

    logic                            en_q;
    logic [NUM_CTR-1:0][CFG_W-1:0]   cfg_q;
    logic                            ctrl_hit;
    logic [NUM_CTR-1:0]              cfg_hit;
    logic [NUM_CTR-1:0]              val_hit;

    // Decode the address into one hit per register
    always_comb begin
        ctrl_hit = (addr_i == ADDR_W'(CTRL_OFF));
        for (int i = 0; i < NUM_CTR; i++) begin
            cfg_hit[i] = (addr_i == ADDR_W'(CFG0_OFF - STRIDE * i));
            val_hit[i] = (addr_i == ADDR_W'(VAL0_OFF - STRIDE * i));
        end
    end

    // Update the control and configuration registers on writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            cfg_q <= '0;
        end else if (wr_i) begin
            if (ctrl_hit) en_q <= wdata_i[0];
            for (int i = 0; i < NUM_CTR; i++)
                if (cfg_hit[i]) cfg_q[i] <= wdata_i[CFG_W-1:0];
        end
    end

    // Select the read data for the addressed register
    always_comb begin
        rdata_o = '0;
        if (ctrl_hit) rdata_o[0] = en_q;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (cfg_hit[i]) rdata_o[CFG_W-1:0] = cfg_q[i];
            if (val_hit[i]) rdata_o = cnt_i[i];
        end
    end

    // Route the outputs: source fields, value write strobes and write data
    always_comb begin
        for (int i = 0; i < NUM_CTR; i++) begin
            src_o[i]    = cfg_q[i][CFG_W-1:MODE_W];
            val_we_o[i] = wr_i & val_hit[i];
        end
    end
    assign glob_en_o   = en_q;
    assign val_wdata_o = wdata_i;

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_cfg_chk
        // R10
        cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && cfg_hit[g]) |=> (cfg_q[g] == $past(wdata_i[CFG_W-1:0])));
    end

    // R2
    en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && ctrl_hit) |=> (en_q == $past(wdata_i[0])));
endmodule

// File: rtl/cecu_event_sel.sv
// Event source selector for one counter.
// Returns high when the strobe chosen by the source code is high.
// Code 0 never selects anything. With the extended set disabled, codes at or
// above the base limit never select anything either.
module cecu_event_sel #(
    parameter int NUM_EVT         = 16,
    parameter int SRC_W           = 4,
    parameter bit EXTENDED_EVENTS = 1'b1
) (
    input  logic [NUM_EVT-1:0] strobe_i,
    input  logic [SRC_W-1:0]   src_i,
    output logic               hit_o
);
    import cecu_pkg::*;

    logic picked;

    // Pick the strobe the code points at
    always_comb picked = strobe_i[src_i];

    if (EXTENDED_EVENTS) begin : g_full
        assign hit_o = (src_i != '0) && picked;
    end else begin : g_base
        assign hit_o = (src_i != '0) && (int'(src_i) < BASE_CODE_LIMIT) && picked;
    end
endmodule

// File: rtl/cecu_sat_counter.sv
// One saturating event counter with a software load port.
// A load wins over an increment in the same cycle. An increment at all ones
// is dropped, so the counter sticks at all ones.
module cecu_sat_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_val_i,
    output logic [DATA_W-1:0] cnt_o
);
    localparam logic [DATA_W-1:0] FULL = '1;

    logic [DATA_W-1:0] cnt_q;

    // Load, saturating increment, or hold
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (load_i)                   cnt_q <= load_val_i;
        else if (inc_i && cnt_q != FULL)   cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R6
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == FULL && !load_i) |=> (cnt_q == FULL));
    // R7
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(load_val_i)));
    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ((cnt_q - $past(cnt_q)) <= DATA_W'(1)));
endmodule

// File: rtl/cache_event_counter_unit.sv
// Top level of the saturating cache event counter unit.
// Joins the register file, one event selector per counter and one saturating
// counter per counter. A counter increments when the global enable is set and
// its selected strobe is high.
module cache_event_counter_unit #(
    parameter int NUM_CTR         = 2,
    parameter int DATA_W          = 32,
    parameter int ADDR_W          = 5,
    parameter int NUM_EVT         = 16,
    parameter bit EXTENDED_EVENTS = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic               reg_wr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    input  logic [NUM_EVT-1:0] evt_strobe_i
);
    import cecu_pkg::*;

    localparam int SRC_W = $clog2(NUM_EVT);

    logic                           glob_en;
    logic [NUM_CTR-1:0][SRC_W-1:0]  src;
    logic [NUM_CTR-1:0]             val_we;
    logic [DATA_W-1:0]              val_wdata;
    logic [NUM_CTR-1:0][DATA_W-1:0] cnt;
    logic [NUM_CTR-1:0]             hit;

    cecu_regfile #(
        .NUM_CTR(NUM_CTR), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .SRC_W(SRC_W), .MODE_W(MODE_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .addr_i(reg_addr_i), .wr_i(reg_wr_i), .wdata_i(reg_wdata_i),
        .rdata_o(reg_rdata_o), .cnt_i(cnt), .glob_en_o(glob_en),
        .src_o(src), .val_we_o(val_we), .val_wdata_o(val_wdata)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        cecu_event_sel #(
            .NUM_EVT(NUM_EVT), .SRC_W(SRC_W), .EXTENDED_EVENTS(EXTENDED_EVENTS)
        ) u_sel (
            .strobe_i(evt_strobe_i), .src_i(src[g]), .hit_o(hit[g])
        );

        cecu_sat_counter #(.DATA_W(DATA_W)) u_cnt (
            .clk(clk), .rst_n(rst_n),
            .inc_i(glob_en & hit[g]),
            .load_i(val_we[g]), .load_val_i(val_wdata),
            .cnt_o(cnt[g])
        );

        // R4
        freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!glob_en && !val_we[g]) |=> $stable(cnt[g]));
        // R5
        off_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (src[g] == '0 && !val_we[g]) |=> $stable(cnt[g]));
    end
endmodule

// File: tb/tb_cache_event_counter_unit.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_cache_event_counter_unit;
    import cecu_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_b;
    logic [15:0] evt = '0;
    int          n_checks = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    cache_event_counter_unit dut (
        .clk(clk), .rst_n(rst_n), .reg_addr_i(addr), .reg_wr_i(wr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_strobe_i(evt));

    cache_event_counter_unit #(.EXTENDED_EVENTS(1'b0)) dut_base (
        .clk(clk), .rst_n(rst_n), .reg_addr_i(addr), .reg_wr_i(wr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata_b), .evt_strobe_i(evt));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wr = 1'b1; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [4:0] a, output logic [31:0] d, output logic [31:0] db);
        @(negedge clk); addr = a; #1; d = rdata; db = rdata_b;
    endtask

    task automatic pulse(input event_code_e code, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); evt = 16'(1) << code;
            @(negedge clk); evt = '0;
        end
    endtask

    task automatic test_reset;
        logic [31:0] d, db;
        for (int a = 0; a <= 16; a += 4) begin
            reg_rd(5'(a), d, db);
            check("R1 reset value", d, 32'h0);
            check("R1 reset value base", db, 32'h0);
        end
    endtask

    task automatic test_count;
        logic [31:0] d, db;
        reg_wr(5'h08, 32'(EV_DRD_HIT) << 2);
        reg_wr(5'h04, 32'(EV_DRD_REQ) << 2);
        reg_wr(5'h00, 32'h1);
        pulse(EV_DRD_HIT, 5);
        pulse(EV_DRD_REQ, 3);
        reg_rd(5'h10, d, db); check("R3 ctr0 count (R2 at 0x10)", d, 32'd5);
        reg_rd(5'h0C, d, db); check("R3 ctr1 count (R2 at 0x0C)", d, 32'd3);
        reg_rd(5'h00, d, db); check("R2 enable readback", d, 32'h1);
    endtask

    task automatic test_freeze;
        logic [31:0] d, db;
        reg_wr(5'h00, 32'h0);
        pulse(EV_DRD_HIT, 4);
        reg_rd(5'h10, d, db); check("R4 frozen while disabled", d, 32'd5);
        reg_wr(5'h00, 32'h1);
    endtask

    task automatic test_off_code;
        logic [31:0] d, db;
        reg_wr(5'h04, 32'h0);
        pulse(EV_DRD_REQ, 2);
        pulse(EV_NONE, 2);
        reg_rd(5'h0C, d, db); check("R5 code 0 never counts", d, 32'd3);
    endtask

    task automatic test_saturate;
        logic [31:0] d, db;
        reg_wr(5'h10, 32'hFFFF_FFFD);
        pulse(EV_DRD_HIT, 5);
        reg_rd(5'h10, d, db); check("R6 sticks at all ones", d, 32'hFFFF_FFFF);
        reg_wr(5'h10, 32'h0);
        reg_rd(5'h10, d, db); check("R7 restart from zero", d, 32'h0);
        pulse(EV_DRD_HIT, 1);
        reg_rd(5'h10, d, db); check("R3 counts after restart", d, 32'd1);
    endtask

    task automatic test_collide;
        logic [31:0] d, db;
        @(negedge clk);
        addr = 5'h10; wr = 1'b1; wdata = 32'h55; evt = 16'(1) << EV_DRD_HIT;
        #1; check("R8 read shows pre-edge value", rdata, 32'd1);
        @(negedge clk); wr = 1'b0; evt = '0;
        reg_rd(5'h10, d, db); check("R7 write wins over event", d, 32'h55);
    endtask

    task automatic test_extended;
        logic [31:0] d, db;
        reg_wr(5'h04, 32'(EV_PF_ALLOC) << 2);
        pulse(EV_PF_ALLOC, 2);
        reg_rd(5'h0C, d, db);
        check("R9 extended code counts", d, 32'd5);
        check("R9 extended code ignored in base variant", db, 32'd3);
        reg_rd(5'h10, d, db); check("R3 ctr0 untouched by other code", d, 32'h55);
    endtask

    task automatic test_cfg_field;
        logic [31:0] d, db;
        reg_wr(5'h08, 32'hFFFF_FFC9);
        reg_rd(5'h08, d, db); check("R10 cfg keeps bits 5:0", d, 32'h09);
        pulse(EV_DRD_HIT, 2);
        reg_rd(5'h10, d, db); check("R10 mode bits do not block counting", d, 32'h57);
        reg_rd(5'h14, d, db); check("R2 unmapped reads zero", d, 32'h0);
        reg_rd(5'h02, d, db); check("R2 misaligned reads zero", d, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_count();
        test_freeze();
        test_off_code();
        test_saturate();
        test_collide();
        test_extended();
        test_cfg_field();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule